// File: doc/BRIEF.md
# Write-Inhibit and Power-On Guard

This block sits between the synchronised control strobes of a nonvolatile memory port and the write controller behind it. It lets a write begin only when the supply is healthy, the power-on hold-off has run out, the strobe levels call for a write, and the write condition has lasted long enough not to be noise. When all of that holds it issues one single-cycle start pulse. The write controller needs no further qualification of its own.

The supply is seen only as a digital "supply good" flag, which already carries the threshold decision. Every time that flag rises, a hold-off count of `HOLD_CYC` clock cycles runs before the guard arms. A write condition that is already present when the guard arms is refused. The strobes have to go idle and then make a fresh, long enough active run.

The controller has seven states. `GS_OFF` means the supply is bad. `GS_HOLD` counts the hold-off. `GS_REARM` waits for a stale strobe to be released. `GS_IDLE` is armed and waiting. `GS_FILTER` is measuring an active run. `GS_FIRE` is the one cycle of the start pulse. `GS_RELEASE` waits for the strobe to end after a start.

The transitions are these:
- off-to-hold: the supply flag is high.
- hold-to-idle: the hold-off ends with the strobe idle.
- hold-to-rearm: the hold-off ends with the strobe active.
- rearm-to-idle: the strobe is idle.
- idle-to-filter: the strobe turns active.
- filter-to-idle: a run ends too short.
- idle-or-filter-to-fire: the `MIN_PULSE`-th active sample.
- fire-to-release: the strobe is still active.
- fire-to-idle: the strobe is idle.
- release-to-idle: the strobe is idle.
- any-to-off: the supply flag is low.

Top module: `wr_guard`

## Requirements
- R1: While `pwr_good` is sampled low, `wr_go` is low in the following cycle. A strobe run that coincides with a low supply never produces a start.
- R2: Let edge k be the first rising clock edge that samples `pwr_good` high after it was low, or after reset. The guard arms at edge k+`HOLD_CYC`. A write condition sampled at or before that edge cannot lead to a start.
- R3: The write condition is `chip_sel_n`=0, `wr_en_n`=0 and `rd_en_n`=1 at the same edge. Every other combination counts as idle. This holds whichever of the two write strobes falls last.
- R4: A start needs the write condition sampled at `MIN_PULSE` consecutive edges. A run of `MIN_PULSE`-1 or fewer edges is discarded.
- R5: `wr_go` is high for exactly the one cycle that follows the `MIN_PULSE`-th active edge of a run. A longer run gives only one start.
- R6: A low sample of `pwr_good`, however short, clears the hold-off progress. The full `HOLD_CYC` delay restarts on recovery, and any run being measured is dropped.
- R7: If the write condition is active at the arming edge, no start comes from that run. The condition must be sampled idle at least once, and a new run of `MIN_PULSE` edges is then needed.
- R8: While `rst_n` is low, `wr_go` is low. After reset the hold-off restarts from zero, even if `pwr_good` was high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Synchronised flag, high when the supply is above the write threshold |
| chip_sel_n | input | 1 | Synchronised active-low chip select |
| wr_en_n | input | 1 | Synchronised active-low write strobe |
| rd_en_n | input | 1 | Synchronised active-low output enable; low inhibits writes |
| wr_go | output | 1 | Qualified write-start pulse, one cycle wide |

## Verification
The assertions assume that all four control inputs are already synchronous to `clk` and change only away from the rising edge. The bench keeps to this by driving them only at falling edges. The assertions also assume that `pwr_good` is a level and not a clock-rate toggle, so that the hold-off window means something. The bench holds it steady for many cycles, except in the deliberate one-cycle drop. The bench uses `HOLD_CYC`=20 and `MIN_PULSE`=3, so that every boundary of both windows is reached within a few hundred cycles.

// File: rtl/wg_pkg.sv
package wg_pkg;

    typedef enum logic [2:0] {
        GS_OFF     = 3'd0,
        GS_HOLD    = 3'd1,
        GS_REARM   = 3'd2,
        GS_IDLE    = 3'd3,
        GS_FILTER  = 3'd4,
        GS_FIRE    = 3'd5,
        GS_RELEASE = 3'd6
    } wg_state_e;

endpackage

// File: rtl/wg_holdoff_timer.sv
module wg_holdoff_timer #(
    parameter int HOLD_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    output logic hold_done
);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC);

    logic [HW-1:0] hold_cnt;

    // Counts edges with the supply good; any low sample restarts from zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (!pwr_good) begin
            hold_cnt <= '0;
        end else if (hold_cnt != HOLD_LAST) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    always_comb hold_done = (hold_cnt == HOLD_LAST);

endmodule

// File: rtl/wg_strobe_qual.sv
module wg_strobe_qual (
    input  logic chip_sel_n,
    input  logic wr_en_n,
    input  logic rd_en_n,
    output logic wr_cond
);
    // Write condition: select and write strobe low, output enable high.
    always_comb wr_cond = !chip_sel_n && !wr_en_n && rd_en_n;

endmodule

// File: rtl/wg_run_counter.sv
module wg_run_counter #(
    parameter int MIN_PULSE = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_cond,
    output logic [$clog2(MIN_PULSE+1)-1:0]   run_len
);
    localparam int RW = $clog2(MIN_PULSE + 1);
    localparam logic [RW-1:0] RUN_SAT = RW'(MIN_PULSE);

    // Consecutive active samples, saturating at MIN_PULSE.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (!wr_cond) begin
            run_len <= '0;
        end else if (run_len != RUN_SAT) begin
            run_len <= run_len + 1'b1;
        end
    end

endmodule

// File: rtl/wg_guard_fsm.sv
module wg_guard_fsm
    import wg_pkg::*;
#(
    parameter int MIN_PULSE = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             pwr_good,
    input  logic                             hold_done,
    input  logic                             wr_cond,
    input  logic [$clog2(MIN_PULSE+1)-1:0]   run_len,
    output logic                             wr_go
);
    localparam int RW = $clog2(MIN_PULSE + 1);
    localparam logic [RW-1:0] RUN_LAST = RW'(MIN_PULSE - 1);

    wg_state_e state_q, state_d;
    logic      run_complete;

    always_comb run_complete = wr_cond && (run_len == RUN_LAST);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (!pwr_good) begin
            state_d = GS_OFF;
        end else begin
            unique case (state_q)
                GS_OFF:     state_d = GS_HOLD;
                GS_HOLD:    if (hold_done) state_d = wr_cond ? GS_REARM : GS_IDLE;
                GS_REARM:   if (!wr_cond) state_d = GS_IDLE;
                GS_IDLE: begin
                    if (run_complete)      state_d = GS_FIRE;
                    else if (wr_cond)      state_d = GS_FILTER;
                end
                GS_FILTER: begin
                    if (!wr_cond)          state_d = GS_IDLE;
                    else if (run_complete) state_d = GS_FIRE;
                end
                GS_FIRE:    state_d = wr_cond ? GS_RELEASE : GS_IDLE;
                GS_RELEASE: if (!wr_cond) state_d = GS_IDLE;
                default:    state_d = GS_OFF;
            endcase
        end
    end

    // Output decode.
    always_comb begin
        wr_go = 1'b0;
        unique case (state_q)
            GS_FIRE: wr_go = 1'b1;
            default: wr_go = 1'b0;
        endcase
    end

endmodule

// File: rtl/wr_guard.sv
module wr_guard #(
    parameter int HOLD_CYC  = 250000,
    parameter int MIN_PULSE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic chip_sel_n,
    input  logic wr_en_n,
    input  logic rd_en_n,
    output logic wr_go
);
    localparam int RW = $clog2(MIN_PULSE + 1);

    logic          hold_done;
    logic          wr_cond;
    logic [RW-1:0] run_len;

    wg_holdoff_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good),
        .hold_done (hold_done)
    );

    wg_strobe_qual u_qual (
        .chip_sel_n (chip_sel_n),
        .wr_en_n    (wr_en_n),
        .rd_en_n    (rd_en_n),
        .wr_cond    (wr_cond)
    );

    wg_run_counter #(.MIN_PULSE(MIN_PULSE)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_cond (wr_cond),
        .run_len (run_len)
    );

    wg_guard_fsm #(.MIN_PULSE(MIN_PULSE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good),
        .hold_done (hold_done),
        .wr_cond   (wr_cond),
        .run_len   (run_len),
        .wr_go     (wr_go)
    );

endmodule

// File: rtl/wr_guard_chk.sv
module wr_guard_chk #(
    parameter int HOLD_CYC  = 250000,
    parameter int MIN_PULSE = 2
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_good,
    input logic chip_sel_n,
    input logic wr_en_n,
    input logic rd_en_n,
    input logic wr_go
);
    localparam int SW = $clog2(HOLD_CYC + 2);
    localparam int AW = $clog2(MIN_PULSE + 1);
    localparam logic [SW-1:0] SUP_SAT = SW'(HOLD_CYC + 1);
    localparam logic [AW-1:0] ACT_SAT = AW'(MIN_PULSE);

    logic [SW-1:0] sup_seen;
    logic [AW-1:0] act_seen;
    logic          cond_now;

    always_comb cond_now = !chip_sel_n && !wr_en_n && rd_en_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sup_seen <= '0;
            act_seen <= '0;
        end else begin
            if (!pwr_good)              sup_seen <= '0;
            else if (sup_seen != SUP_SAT) sup_seen <= sup_seen + 1'b1;
            if (!cond_now)              act_seen <= '0;
            else if (act_seen != ACT_SAT) act_seen <= act_seen + 1'b1;
        end
    end

    // R1: no start in the cycle after a low supply sample
    p_supply_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !wr_go);

    // R2, R6: a start needs more than HOLD_CYC good-supply samples
    p_holdoff_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> (sup_seen == SUP_SAT));

    // R3: the last edge before a start saw the write condition
    p_level_inhibit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> $past(cond_now));

    // R4: a start needs MIN_PULSE consecutive active samples
    p_min_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> (act_seen == ACT_SAT));

    // R5: the start pulse is one cycle wide
    p_single_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> !wr_go);

    // R8: no start while reset is applied
    always_comb begin
        if (!rst_n) p_reset_quiet_r8: assert (!wr_go);
    end

endmodule

bind wr_guard wr_guard_chk #(.HOLD_CYC(HOLD_CYC), .MIN_PULSE(MIN_PULSE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good),
    .chip_sel_n (chip_sel_n),
    .wr_en_n    (wr_en_n),
    .rd_en_n    (rd_en_n),
    .wr_go      (wr_go)
);

// File: tb/wr_guard_test.sv
module wr_guard_test;
    localparam int HOLD = 20;
    localparam int MINP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b1;
    logic chip_sel_n = 1'b1;
    logic wr_en_n = 1'b1;
    logic rd_en_n = 1'b1;
    logic wr_go;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    wr_guard #(.HOLD_CYC(HOLD), .MIN_PULSE(MINP)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .chip_sel_n(chip_sel_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
        .wr_go(wr_go)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: wr_go=%b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic set_strobes(input logic cs, input logic we, input logic oe);
        chip_sel_n = cs;
        wr_en_n    = we;
        rd_en_n    = oe;
    endtask

    // Watch n cycles at falling edges; a start is expected only at cycle fire_at.
    task automatic observe(input int n, input int fire_at, input string tag);
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            check(wr_go, (i == fire_at), tag);
        end
    endtask

    task automatic idle_wait(input int n);
        set_strobes(1'b1, 1'b1, 1'b1);
        observe(n, 0, "idle");
    endtask

    task automatic power_cycle_and_arm();
        @(negedge clk);
        pwr_good = 1'b0;
        set_strobes(1'b1, 1'b1, 1'b1);
        observe(2, 0, "R1 supply low");
        pwr_good = 1'b1;
        observe(HOLD + 1, 0, "R2 hold-off quiet");
    endtask

    task automatic t_reset();
        check(wr_go, 1'b0, "R8 during reset");
        @(negedge clk);
        check(wr_go, 1'b0, "R8 during reset");
        rst_n = 1'b1;
        set_strobes(1'b0, 1'b0, 1'b1);
        observe(MINP + 2, 0, "R8 hold-off restarts after reset");
        idle_wait(HOLD);
        set_strobes(1'b0, 1'b0, 1'b1);
        observe(MINP, MINP, "R8 start once armed");
        idle_wait(3);
    endtask

    task automatic t_holdoff_boundary();
        power_cycle_and_arm();
        // The run starting at the arming edge is refused.
        @(negedge clk);
        pwr_good = 1'b0;
        observe(1, 0, "R1 supply low");
        pwr_good = 1'b1;
        observe(HOLD, 0, "R2 before arming");
        set_strobes(1'b0, 1'b0, 1'b1);
        observe(MINP + 2, 0, "R2 run at arming edge");
        idle_wait(2);
        // Earliest accepted run: first active edge just after arming.
        @(negedge clk);
        pwr_good = 1'b0;
        observe(1, 0, "R1 supply low");
        pwr_good = 1'b1;
        observe(HOLD + 1, 0, "R2 before arming");
        set_strobes(1'b0, 1'b0, 1'b1);
        observe(MINP + 1, MINP, "R2 earliest start");
        idle_wait(2);
    endtask

    task automatic t_stale_strobe();
        @(negedge clk);
        pwr_good = 1'b0;
        observe(1, 0, "R1 supply low");
        pwr_good = 1'b1;
        set_strobes(1'b0, 1'b0, 1'b1);
        observe(HOLD + MINP + 5, 0, "R7 stale strobe held");
        idle_wait(1);
        set_strobes(1'b0, 1'b0, 1'b1);
        observe(MINP, MINP, "R7 fresh run accepted");
        idle_wait(2);
    endtask

    task automatic t_inhibit_levels();
        power_cycle_and_arm();
        set_strobes(1'b1, 1'b0, 1'b1);
        observe(MINP + 2, 0, "R3 select high");
        idle_wait(1);
        set_strobes(1'b0, 1'b1, 1'b1);
        observe(MINP + 2, 0, "R3 write strobe high");
        idle_wait(1);
        set_strobes(1'b0, 1'b0, 1'b0);
        observe(MINP + 2, 0, "R3 output enable low");
        // Output enable rising mid-hold starts a fresh run.
        rd_en_n = 1'b1;
        observe(MINP, MINP, "R3 run counted from enable release");
        idle_wait(2);
        // Select-controlled: write strobe falls first.
        set_strobes(1'b1, 1'b0, 1'b1);
        observe(2, 0, "R3 write strobe alone");
        chip_sel_n = 1'b0;
        observe(MINP, MINP, "R3 select-controlled start");
        idle_wait(2);
    endtask

    task automatic t_width();
        set_strobes(1'b0, 1'b0, 1'b1);
        observe(MINP - 1, 0, "R4 short run");
        idle_wait(2);
        set_strobes(1'b0, 1'b0, 1'b1);
        observe(1, 0, "R4 one-edge glitch");
        idle_wait(2);
        set_strobes(1'b0, 1'b0, 1'b1);
        observe(MINP, MINP, "R4 exact width");
        idle_wait(3);
        set_strobes(1'b0, 1'b0, 1'b1);
        observe(3 * MINP, MINP, "R5 long run single start");
        idle_wait(3);
        set_strobes(1'b0, 1'b0, 1'b1);
        observe(MINP, MINP, "R5 next run after release");
        idle_wait(2);
    endtask

    task automatic t_supply_drop();
        // Drop during a run in progress.
        set_strobes(1'b0, 1'b0, 1'b1);
        observe(MINP - 1, 0, "R6 run before drop");
        pwr_good = 1'b0;
        observe(3, 0, "R6 drop aborts run");
        pwr_good = 1'b1;
        idle_wait(HOLD + 2);
        set_strobes(1'b0, 1'b0, 1'b1);
        observe(MINP, MINP, "R6 start after full hold-off");
        idle_wait(2);
        // A one-cycle dip restarts the full delay.
        pwr_good = 1'b0;
        observe(1, 0, "R1 supply dip");
        pwr_good = 1'b1;
        observe(HOLD - 2, 0, "R6 partial hold-off");
        set_strobes(1'b0, 1'b0, 1'b1);
        observe(MINP, 0, "R6 run inside restarted hold-off");
        idle_wait(4);
        set_strobes(1'b0, 1'b0, 1'b1);
        observe(MINP, MINP, "R6 start after recovery");
        idle_wait(2);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_holdoff_boundary();
        t_stale_strobe();
        t_inhibit_levels();
        t_width();
        t_supply_drop();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule